// File: doc/BRIEF.md
# Priority-Ordered Circular Process Queue Mover

This block moves one process descriptor from the circular list it sits on to another circular list. The destination list is kept in descending priority order. A requester hands it a source queue address, a destination queue address and a descriptor index, and can flag the source as unknown. The block then walks the lists through a single-port word memory. It finds the descriptor's predecessor and bypasses the descriptor. It repairs the source queue word, or records the old successor in the descriptor's flags word when the source is unknown. Finally it splices the descriptor into the destination list at its priority position.

Each list is reached only through its tail: a queue word holds the tail index, and the tail's next field points back to the head. Index zero means an empty queue. Descriptor `i` occupies four words starting at address `4*i`, in the order link, flags, context, timeout. The memory returns read data on the cycle after a read request.

Top module: `pq_mover`

## Requirements
- R1: After reset `cmd_ready` is high, `done` and `requeued` are low, and no memory access is made while the block is idle.
- R2: When the descriptor's link next field points to itself and the source is given, the source queue word's tail field (bits IDX_W+1..2, 11..2 at default) is written to zero.
- R3: The predecessor's link word (address 4×index, next field in bits IDX_W+1..2) receives the removed descriptor's old next index, which bypasses it in its list.
- R4: With a given source, the source queue's tail becomes the predecessor when the removed descriptor was the tail; otherwise the source queue word keeps its value.
- R5: With a null source, the descriptor's flags word (address 4×index+1) gets the old next index in its cleanup field (bits IDX_W+1..2), and no queue word is written.
- R6: Insertion into an empty destination makes the descriptor its tail and makes the descriptor's next field point to itself.
- R7: When the destination tail's priority (link bits 14..12) is greater than or equal to the descriptor's, the descriptor goes after the tail and becomes the new tail, so equal priorities keep arrival order.
- R8: Otherwise the descriptor goes after the last entry, counted from the head, whose priority is greater than or equal to its own, and the destination queue word keeps its value.
- R9: Every write replaces only the index field (bits IDX_W+1..2). The failed bit 15, the priority bits 14..12, the vector bit 0 and all other bits are kept. Context and timeout words are never written.
- R10: A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low and command inputs are ignored until the move ends. `done` is high for exactly one cycle. `requeued` rises the cycle after `done` and holds until `requeued_clr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Requeue command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_src_null | input | 1 | Source queue unknown |
| cmd_src_addr | input | IDX_W+2 | Word address of source queue word |
| cmd_dst_addr | input | IDX_W+2 | Word address of destination queue word |
| cmd_idx | input | IDX_W | Index of descriptor to move |
| done | output | 1 | One-cycle completion pulse |
| requeued | output | 1 | Sticky completion flag |
| requeued_clr | input | 1 | Clears the sticky flag |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | IDX_W+2 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |

## Verification
The checks assume well-formed input. Every list is a closed circle in descending priority order from the head, and the named descriptor really sits on the given source queue. A null source is never paired with a destination equal to the queue the descriptor is on, and the requester clears `requeued` only when it wants to. The bench meets these assumptions by rebuilding every list from an arithmetic model before each trial. It fills all unused bits with random values and draws the source, destination, descriptor and null flag from the model's non-empty queues. It then predicts the whole table word by word.

// File: rtl/pq_pkg.sv
package pq_pkg;
    localparam int WORD_W   = 16;
    localparam int FIELD_LO = 2;
    localparam int PRIO_LO  = 12;
    localparam int PRIO_W   = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [4:0] {
        S_IDLE,
        S_LINK_RD,
        S_LINK_WT,
        S_SRCQ_RD,
        S_SRCQ_WT,
        S_SRCH_RD,
        S_SRCH_WT,
        S_UNLINK_WR,
        S_FIX_RD,
        S_FIX_WT,
        S_FIX_WR,
        S_DSTQ_RD,
        S_DSTQ_WT,
        S_TAIL_RD,
        S_TAIL_WT,
        S_WALK_RD,
        S_WALK_WT,
        S_DSTQ_WR,
        S_PREV_WR,
        S_PSB_WR,
        S_DONE
    } walk_state_e;
endpackage

// File: rtl/pq_field_dec.sv
module pq_field_dec
    import pq_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  word_t            word_i,
    output logic [IDX_W-1:0] idx_o,
    output prio_t            prio_o
);
    localparam int FIELD_HI = FIELD_LO + IDX_W - 1;

    assign idx_o  = word_i[FIELD_HI:FIELD_LO];
    assign prio_o = word_i[PRIO_LO +: PRIO_W];
endmodule

// File: rtl/pq_field_ins.sv
module pq_field_ins
    import pq_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  word_t            word_i,
    input  logic [IDX_W-1:0] idx_i,
    output word_t            word_o
);
    localparam int FIELD_HI = FIELD_LO + IDX_W - 1;

    always_comb begin
        word_o                    = word_i;
        word_o[FIELD_HI:FIELD_LO] = idx_i;
    end
endmodule

// File: rtl/pq_walker.sv
module pq_walker
    import pq_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_src_null,
    input  logic [IDX_W+1:0]  cmd_src_addr,
    input  logic [IDX_W+1:0]  cmd_dst_addr,
    input  logic [IDX_W-1:0]  cmd_idx,
    output logic              idle_o,
    output logic              done_o,
    output logic              mem_en,
    output logic              mem_we,
    output logic [IDX_W+1:0]  mem_addr,
    output word_t             mem_wdata,
    input  word_t             mem_rdata
);
    localparam int AW = IDX_W + 2;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [AW-1:0]    addr_t;

    walk_state_e state_q, state_d;

    logic  src_null_q;
    addr_t src_q, dst_q;
    idx_t  psb_q, nxt0_q, cur_q, prev_q, after_q;
    word_t link_q, word_q, dstw_q;
    prio_t prio_q;
    logic  empty_q;

    idx_t  rd_next;
    prio_t rd_prio;
    word_t mword;
    idx_t  midx;
    addr_t fix_addr;

    pq_field_dec #(.IDX_W(IDX_W)) u_dec (
        .word_i (mem_rdata),
        .idx_o  (rd_next),
        .prio_o (rd_prio)
    );

    pq_field_ins #(.IDX_W(IDX_W)) u_ins (
        .word_i (mword),
        .idx_i  (midx),
        .word_o (mem_wdata)
    );

    assign fix_addr = src_null_q ? {psb_q, 2'b01} : src_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (cmd_valid) state_d = S_LINK_RD;
            S_LINK_RD:   state_d = S_LINK_WT;
            S_LINK_WT: begin
                if (rd_next == psb_q)  state_d = S_FIX_RD;
                else if (src_null_q)   state_d = S_SRCH_RD;
                else                   state_d = S_SRCQ_RD;
            end
            S_SRCQ_RD:   state_d = S_SRCQ_WT;
            S_SRCQ_WT:   state_d = S_SRCH_RD;
            S_SRCH_RD:   state_d = S_SRCH_WT;
            S_SRCH_WT:   state_d = (rd_next == psb_q) ? S_UNLINK_WR : S_SRCH_RD;
            S_UNLINK_WR: state_d = S_FIX_RD;
            S_FIX_RD:    state_d = S_FIX_WT;
            S_FIX_WT: begin
                if (src_null_q || (rd_next == psb_q)) state_d = S_FIX_WR;
                else                                  state_d = S_DSTQ_RD;
            end
            S_FIX_WR:    state_d = S_DSTQ_RD;
            S_DSTQ_RD:   state_d = S_DSTQ_WT;
            S_DSTQ_WT:   state_d = (rd_next == '0) ? S_DSTQ_WR : S_TAIL_RD;
            S_TAIL_RD:   state_d = S_TAIL_WT;
            S_TAIL_WT:   state_d = (rd_prio >= prio_q) ? S_DSTQ_WR : S_WALK_RD;
            S_WALK_RD:   state_d = S_WALK_WT;
            S_WALK_WT:   state_d = (prio_q > rd_prio) ? S_PREV_WR : S_WALK_RD;
            S_DSTQ_WR:   state_d = empty_q ? S_PSB_WR : S_PREV_WR;
            S_PREV_WR:   state_d = S_PSB_WR;
            S_PSB_WR:    state_d = S_DONE;
            S_DONE:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // Memory-port outputs
    always_comb begin
        mem_en   = 1'b0;
        mem_we   = 1'b0;
        mem_addr = {psb_q, 2'b00};
        mword    = word_q;
        midx     = psb_q;
        unique case (state_q)
            S_LINK_RD: mem_en = 1'b1;
            S_SRCQ_RD: begin
                mem_en   = 1'b1;
                mem_addr = src_q;
            end
            S_SRCH_RD, S_TAIL_RD, S_WALK_RD: begin
                mem_en   = 1'b1;
                mem_addr = {cur_q, 2'b00};
            end
            S_UNLINK_WR: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {prev_q, 2'b00};
                midx     = nxt0_q;
            end
            S_FIX_RD: begin
                mem_en   = 1'b1;
                mem_addr = fix_addr;
            end
            S_FIX_WR: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = fix_addr;
                midx     = src_null_q ? nxt0_q : prev_q;
            end
            S_DSTQ_RD: begin
                mem_en   = 1'b1;
                mem_addr = dst_q;
            end
            S_DSTQ_WR: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_q;
                mword    = dstw_q;
            end
            S_PREV_WR: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {prev_q, 2'b00};
            end
            S_PSB_WR: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mword    = link_q;
                midx     = after_q;
            end
            default: ;
        endcase
    end

    assign idle_o = (state_q == S_IDLE);
    assign done_o = (state_q == S_DONE);

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_null_q <= 1'b0;
            src_q      <= '0;
            dst_q      <= '0;
            psb_q      <= '0;
            nxt0_q     <= '0;
            cur_q      <= '0;
            prev_q     <= '0;
            after_q    <= '0;
            link_q     <= '0;
            word_q     <= '0;
            dstw_q     <= '0;
            prio_q     <= '0;
            empty_q    <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (cmd_valid) begin
                    src_null_q <= cmd_src_null;
                    src_q      <= cmd_src_addr;
                    dst_q      <= cmd_dst_addr;
                    psb_q      <= cmd_idx;
                end
                S_LINK_WT: begin
                    link_q <= mem_rdata;
                    nxt0_q <= rd_next;
                    prio_q <= rd_prio;
                    cur_q  <= rd_next;
                    prev_q <= '0;
                end
                S_SRCQ_WT: cur_q <= rd_next;
                S_SRCH_WT: begin
                    word_q <= mem_rdata;
                    if (rd_next == psb_q) prev_q <= cur_q;
                    else                  cur_q  <= rd_next;
                end
                S_FIX_WT: word_q <= mem_rdata;
                S_DSTQ_WT: begin
                    dstw_q  <= mem_rdata;
                    cur_q   <= rd_next;
                    empty_q <= (rd_next == '0);
                    after_q <= psb_q;
                end
                S_TAIL_WT: begin
                    word_q  <= mem_rdata;
                    prev_q  <= cur_q;
                    after_q <= rd_next;
                    cur_q   <= rd_next;
                end
                S_WALK_WT: begin
                    if (prio_q > rd_prio) begin
                        after_q <= cur_q;
                    end else begin
                        prev_q <= cur_q;
                        word_q <= mem_rdata;
                        cur_q  <= rd_next;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pq_status.sv
module pq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic finish_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_o <= 1'b0;
        else if (finish_i) flag_o <= 1'b1;
        else if (clr_i)    flag_o <= 1'b0;
    end
endmodule

// File: rtl/pq_mover.sv
module pq_mover
    import pq_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_src_null,
    input  logic [IDX_W+1:0] cmd_src_addr,
    input  logic [IDX_W+1:0] cmd_dst_addr,
    input  logic [IDX_W-1:0] cmd_idx,
    output logic             done,
    output logic             requeued,
    input  logic             requeued_clr,
    output logic             mem_en,
    output logic             mem_we,
    output logic [IDX_W+1:0] mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata
);
    pq_walker #(.IDX_W(IDX_W)) u_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_src_null (cmd_src_null),
        .cmd_src_addr (cmd_src_addr),
        .cmd_dst_addr (cmd_dst_addr),
        .cmd_idx      (cmd_idx),
        .idle_o       (cmd_ready),
        .done_o       (done),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata)
    );

    pq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .finish_i (done),
        .clr_i    (requeued_clr),
        .flag_o   (requeued)
    );
endmodule

// File: rtl/pq_mover_checker.sv
module pq_mover_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic done,
    input logic requeued,
    input logic requeued_clr,
    input logic mem_en
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_en);

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_ready);

    a_r10_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> requeued);

    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (requeued && !requeued_clr) |=> requeued);

    a_r10_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (requeued && requeued_clr && !done) |=> !requeued);
endmodule

bind pq_mover pq_mover_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .done         (done),
    .requeued     (requeued),
    .requeued_clr (requeued_clr),
    .mem_en       (mem_en)
);

// File: tb/pq_mover_bench.sv
module pq_mover_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W  = 4;
    localparam int AW     = IDX_W + 2;
    localparam int NW     = 1 << AW;
    localparam int ND     = 1 << IDX_W;
    localparam int NQ     = 4;
    localparam int TRIALS = 300;
    localparam logic [15:0] FMASK = 16'(((1 << IDX_W) - 1) << 2);

    logic clk, rst_n;
    logic cmd_valid, cmd_ready, cmd_src_null;
    logic [AW-1:0] cmd_src_addr, cmd_dst_addr;
    logic [IDX_W-1:0] cmd_idx;
    logic done, requeued, requeued_clr;
    logic mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic ld_en;
    logic [AW-1:0] ld_addr;
    logic [15:0] ld_data;

    logic [15:0] mem [NW];

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    int ql [NQ][ND];
    int qn [NQ];
    int pr [ND];
    logic [15:0] init_m [NW];
    logic [15:0] exp_m [NW];
    int s, d, psb, old_next;
    bit nul, src_emptied, dst_was_empty, appended;

    pq_mover #(.IDX_W(IDX_W)) u_pq_mover (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_src_null(cmd_src_null), .cmd_src_addr(cmd_src_addr),
        .cmd_dst_addr(cmd_dst_addr), .cmd_idx(cmd_idx), .done(done),
        .requeued(requeued), .requeued_clr(requeued_clr), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    function automatic logic [15:0] setf(logic [15:0] w, int idx);
        logic [15:0] v;
        v = 16'(idx) << 2;
        return (w & ~FMASK) | (v & FMASK);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic insert_sorted(int q, int idx);
        int pos = 0;
        for (int k = 0; k < qn[q]; k++) if (pr[ql[q][k]] >= pr[idx]) pos = k + 1;
        for (int k = qn[q]; k > pos; k--) ql[q][k] = ql[q][k-1];
        ql[q][pos] = idx;
        qn[q]++;
    endtask

    task automatic link_list(int q);
        for (int k = 0; k < qn[q]; k++)
            exp_m[4*ql[q][k]] = setf(exp_m[4*ql[q][k]], ql[q][(k+1) % qn[q]]);
    endtask

    task automatic build_trial();
        int k;
        for (int q = 0; q < NQ; q++) qn[q] = 0;
        for (int i = 1; i < ND; i++) begin
            int q;
            pr[i] = $urandom_range(0, 3);
            q = (i == 1) ? $urandom_range(0, NQ-1) : $urandom_range(0, NQ);
            if (q < NQ) insert_sorted(q, i);
        end
        for (int a = 0; a < NW; a++) init_m[a] = 16'($urandom);
        for (int i = 1; i < ND; i++)
            init_m[4*i] = (init_m[4*i] & 16'h8fff) | (16'(pr[i]) << 12);
        for (int a = 0; a < NW; a++) exp_m[a] = init_m[a];
        for (int q = 0; q < NQ; q++) begin
            exp_m[q] = setf(exp_m[q], (qn[q] > 0) ? ql[q][qn[q]-1] : 0);
            link_list(q);
        end
        for (int a = 0; a < NW; a++) init_m[a] = exp_m[a];
        do s = $urandom_range(0, NQ-1); while (qn[s] == 0);
        k = $urandom_range(0, qn[s]-1);
        psb = ql[s][k];
        old_next = ql[s][(k+1) % qn[s]];
        d = $urandom_range(0, NQ-1);
        nul = (d != s) && ($urandom_range(0, 1) == 1);
        // expected result
        for (int j = k; j < qn[s]-1; j++) ql[s][j] = ql[s][j+1];
        qn[s]--;
        src_emptied = (qn[s] == 0);
        if (!nul) exp_m[s] = setf(exp_m[s], (qn[s] > 0) ? ql[s][qn[s]-1] : 0);
        else      exp_m[4*psb+1] = setf(exp_m[4*psb+1], old_next);
        link_list(s);
        dst_was_empty = (qn[d] == 0);
        insert_sorted(d, psb);
        appended = (ql[d][qn[d]-1] == psb);
        exp_m[d] = setf(exp_m[d], ql[d][qn[d]-1]);
        link_list(d);
    endtask

    function automatic string ins_tag();
        if (dst_was_empty) return "R6";
        if (appended) return "R7";
        return "R8";
    endfunction

    function automatic string tag_for(int a);
        if (a < NQ) begin
            if (a == d) return ins_tag();
            if (a == s) return nul ? "R5" : (src_emptied ? "R2" : "R4");
            return "R9";
        end
        case (a % 4)
            0: return (a / 4 == psb) ? ins_tag() : "R3";
            1: return (a / 4 == psb && nul) ? "R5" : "R9";
            default: return "R9";
        endcase
    endfunction

    task automatic load_mem();
        for (int a = 0; a < NW; a++) begin
            @(negedge clk);
            ld_en = 1'b1;
            ld_addr = AW'(a);
            ld_data = init_m[a];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_op(bit perturb, bit hold);
        int cycles = 0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_src_null = nul;
        cmd_src_addr = AW'(s);
        cmd_dst_addr = AW'(d);
        cmd_idx = IDX_W'(psb);
        @(negedge clk);
        check(cmd_ready == 1'b0, "R10", "ready after accept", int'(cmd_ready), 0);
        if (perturb) begin
            cmd_idx = cmd_idx ^ IDX_W'(1);
            cmd_src_null = ~cmd_src_null;
            cmd_dst_addr = cmd_dst_addr ^ AW'(1);
        end else cmd_valid = 1'b0;
        while (!done && cycles < 1000) begin
            @(negedge clk);
            cycles++;
        end
        check(done == 1'b1, "R10", "done reached", int'(done), 1);
        cmd_valid = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R10", "done one cycle", int'(done), 0);
        check(requeued == 1'b1, "R10", "requeued set", int'(requeued), 1);
        if (hold) begin
            repeat (3) @(negedge clk);
            check(requeued == 1'b1, "R10", "requeued held", int'(requeued), 1);
            check(cmd_ready == 1'b1, "R10", "ready after done", int'(cmd_ready), 1);
        end
        requeued_clr = 1'b1;
        @(negedge clk);
        requeued_clr = 1'b0;
        check(requeued == 1'b0, "R10", "requeued cleared", int'(requeued), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        cmd_src_null = 1'b0;
        cmd_src_addr = '0;
        cmd_dst_addr = '0;
        cmd_idx = '0;
        requeued_clr = 1'b0;
        ld_en = 1'b0;
        ld_addr = '0;
        ld_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1", "ready at reset", int'(cmd_ready), 1);
        check(done == 1'b0, "R1", "done at reset", int'(done), 0);
        check(requeued == 1'b0, "R1", "requeued at reset", int'(requeued), 0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check(mem_en == 1'b0, "R1", "idle memory access", int'(mem_en), 0);
        end
        for (int t = 0; t < TRIALS; t++) begin
            build_trial();
            load_mem();
            run_op((t % 7) == 3, (t % 5) == 0);
            for (int a = 0; a < NW; a++)
                check(mem[a] == exp_m[a], tag_for(a), $sformatf("trial %0d word %0d", t, a),
                      int'(mem[a]), int'(exp_m[a]));
        end
        report();
    end
endmodule